// File: doc/BRIEF.md
# Programmable Test Pattern Generator

This block is the sending half of a bit error rate tester. On every clock where the gap input allows it, the block puts out one serial test bit. The bit comes from one of two sources. The first is a pseudorandom sequence from a shift register whose active length (1 to 32 stages) and feedback tap set are both set at run time. The second is a user word of 1 to 32 bits that repeats with no pause between repetitions. Both sources step on every enabled clock. The mode setting only picks which one drives the output.

Errors can be put into the stream in two ways. A one-shot strobe inverts the next bit sent. A rate setting inverts one bit in every 10^n sent bits, for n from 1 to 7. Only the transmitted bit is inverted: the shift register and the word position go on as if nothing had happened. The host sets everything through a small write port that takes an address, a data word and a write strobe. A restart strobe brings both sources back to their start points.

Top module: `tpg_top`

## Requirements
- R1: After reset, tx_bit is 0, pseudorandom mode is selected, the active length is 15 with taps at state bits 14 and 13, the shift register holds 1, and rate insertion is off.
- R2: A write with cfg_wr high updates one setting, effective from the next clock. The addresses are: 0 = control (bit 0 selects word mode when 1, bits 3:1 set the rate decade n, 0 = off); 1 = shift register length minus 1 (bits 4:0); 2 = tap mask (bit i feeds back state bit i); 3 = pattern word; 4 = word length minus 1 (bits 4:0).
- R3: In pseudorandom mode, with active length L, each enabled clock sends state bit L-1. The state then shifts up one place, and the parity of the tapped bits below L enters at bit 0. Bits at or above L are kept at zero. Length 6 with taps at bits 5 and 4 gives a period of 63 bits, 32 of them ones.
- R4: On an enabled clock where the active part of the state is all zeros, the block sends 0 and reloads the state with 1.
- R5: In word mode, the word is sent bit 0 first, up to bit (length-1), and then wraps to bit 0 with no gap.
- R6: While clk_en is low, tx_bit and all sequence state hold. The bits sent on enabled clocks are the same as in an ungapped run.
- R7: A high reload sets the shift register to 1, sets the word position to bit 0 and restarts the rate counter. On that clock the block does not advance and tx_bit holds.
- R8: An err_single strobe arms one inversion, which is applied to the next bit sent. Several strobes seen before that bit give a single inversion.
- R9: With rate decade n from 1 to 7, every 10^n-th bit sent is inverted. The count starts over after a control write or a reload, so the first inversion falls on the 10^n-th bit sent after that point. A control write on an enabled clock does not count that clock.
- R10: An inversion affects only tx_bit. Later bits follow the error-free sequence.
- R11: When an armed single error and a rate hit fall on the same bit, that bit is inverted once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Gap control: the block advances only when this is high |
| reload | input | 1 | Restart strobe for both sources and the rate counter |
| err_single | input | 1 | Arms a single bit inversion |
| cfg_wr | input | 1 | Setting write strobe |
| cfg_addr | input | 3 | Setting address |
| cfg_wdata | input | 32 | Setting data |
| tx_bit | output | 1 | Serial test bit, registered |

## Verification
The two error sources can land on the same transmitted bit. The bench sets up this case with decade 1 on an all-zero one-bit word. It arms the single error on the ninth bit after the rate counter restarts, so the pending inversion and the rate hit both fall on the tenth bit. That bit must read 1, and 20 bits must hold exactly two ones. A design that combined the two sources with exclusive-or would send 0 there and only one 1 in total.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic [2:0] {
        CFG_CTRL = 3'd0,
        CFG_LEN  = 3'd1,
        CFG_TAPS = 3'd2,
        CFG_WORD = 3'd3,
        CFG_WLEN = 3'd4
    } cfg_addr_e;

    localparam int unsigned CTRL_MODE_BIT = 0;
    localparam int unsigned CTRL_RATE_LSB = 1;

    function automatic int unsigned decade(input int unsigned n);
        int unsigned v;
        v = 1;
        for (int i = 0; i < 10; i++) begin
            if (i < int'(n)) v = v * 10;
        end
        return v;
    endfunction

endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
    parameter int MAX_LEN = 32,
    parameter int LEN_W   = $clog2(MAX_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic               restart,
    input  logic [LEN_W-1:0]   len_m1,
    input  logic [MAX_LEN-1:0] taps,
    output logic               src_bit
);

    typedef struct packed {
        logic [MAX_LEN-1:0] state;
    } lfsr_s;

    localparam logic [MAX_LEN-1:0] SEED = MAX_LEN'(1);

    lfsr_s              s_d, s_q;
    logic [MAX_LEN-1:0] mask;
    logic [MAX_LEN-1:0] live;
    logic               fb;

    always_comb begin
        for (int i = 0; i < MAX_LEN; i++) begin
            mask[i] = (LEN_W'(i) <= len_m1);
        end
        live    = s_q.state & mask;
        fb      = ^(live & taps);
        src_bit = s_q.state[len_m1];
        s_d     = s_q;
        if (restart) begin
            s_d.state = SEED;
        end else if (adv) begin
            if (live == '0) begin
                s_d.state = SEED;
            end else begin
                s_d.state = {live[MAX_LEN-2:0], fb} & mask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state <= SEED;
        end else begin
            s_q <= s_d;
        end
    end

    p_reseed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !restart && live == '0) |=> (s_q.state == SEED));

    p_restart_seed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (s_q.state == SEED));

endmodule

// File: rtl/tpg_pattern.sv
module tpg_pattern #(
    parameter int MAX_LEN = 32,
    parameter int LEN_W   = $clog2(MAX_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic               restart,
    input  logic [LEN_W-1:0]   wlen_m1,
    input  logic [MAX_LEN-1:0] word,
    output logic               src_bit
);

    typedef struct packed {
        logic [LEN_W-1:0] pos;
    } pat_s;

    pat_s p_d, p_q;

    always_comb begin
        src_bit = word[p_q.pos];
        p_d     = p_q;
        if (restart) begin
            p_d.pos = '0;
        end else if (adv) begin
            p_d.pos = (p_q.pos >= wlen_m1) ? '0 : p_q.pos + LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.pos <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !restart && p_q.pos == wlen_m1) |=> (p_q.pos == '0));

    p_restart_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (p_q.pos == '0));

endmodule

// File: rtl/tpg_errins.sv
module tpg_errins
    import tpg_pkg::*;
#(
    parameter int RATE_W     = 24,
    parameter int MAX_DECADE = 7,
    parameter int SEL_W      = $clog2(MAX_DECADE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             reload,
    input  logic             single_req,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_in,
    output logic             flip
);

    typedef struct packed {
        logic              pend;
        logic [SEL_W-1:0]  sel;
        logic [RATE_W-1:0] cnt;
    } ei_s;

    ei_s               e_d, e_q;
    logic [RATE_W-1:0] period_cur;
    logic [RATE_W-1:0] period_new;
    logic              rate_on;
    logic              hit;

    always_comb begin
        period_cur = RATE_W'(decade({{(32-SEL_W){1'b0}}, e_q.sel}) - 32'd1);
        period_new = RATE_W'(decade({{(32-SEL_W){1'b0}}, sel_in}) - 32'd1);
        rate_on    = (e_q.sel != '0);
        hit        = adv && rate_on && !sel_wr && (e_q.cnt == '0);
        flip       = adv && (e_q.pend || hit);

        e_d      = e_q;
        e_d.pend = (e_q.pend && !adv) || single_req;
        if (sel_wr) begin
            e_d.sel = sel_in;
            e_d.cnt = period_new;
        end else if (reload) begin
            e_d.cnt = period_cur;
        end else if (adv && rate_on) begin
            e_d.cnt = (e_q.cnt == '0) ? period_cur : e_q.cnt - RATE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q.pend <= 1'b0;
            e_q.sel  <= '0;
            e_q.cnt  <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    p_single_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.pend && adv && !single_req) |=> !e_q.pend);

    p_rate_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (e_q.cnt == RATE_W'(decade({{(32-SEL_W){1'b0}}, $past(sel_in)}) - 32'd1)));

endmodule

// File: rtl/tpg_top.sv
module tpg_top
    import tpg_pkg::*;
#(
    parameter int                 MAX_LEN    = 32,
    parameter int                 RATE_W     = 24,
    parameter int                 MAX_DECADE = 7,
    parameter int                 ADDR_W     = 3,
    parameter int                 DEF_LEN_M1 = 14,
    parameter logic [MAX_LEN-1:0] DEF_TAPS   = MAX_LEN'(32'h0000_6000)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clk_en,
    input  logic               reload,
    input  logic               err_single,
    input  logic               cfg_wr,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [MAX_LEN-1:0] cfg_wdata,
    output logic               tx_bit
);

    localparam int LEN_W = $clog2(MAX_LEN);
    localparam int SEL_W = $clog2(MAX_DECADE + 1);

    typedef struct packed {
        logic               word_mode;
        logic [LEN_W-1:0]   len_m1;
        logic [MAX_LEN-1:0] taps;
        logic [MAX_LEN-1:0] word;
        logic [LEN_W-1:0]   wlen_m1;
        logic               tx;
    } top_s;

    top_s             t_d, t_q;
    logic             adv;
    logic             sel_wr;
    logic [SEL_W-1:0] sel_in;
    logic             prbs_bit;
    logic             word_bit;
    logic             flip;

    assign adv    = clk_en && !reload;
    assign sel_wr = cfg_wr && (cfg_addr == ADDR_W'(CFG_CTRL));
    assign sel_in = cfg_wdata[CTRL_RATE_LSB +: SEL_W];

    tpg_lfsr #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .restart (reload),
        .len_m1  (t_q.len_m1),
        .taps    (t_q.taps),
        .src_bit (prbs_bit)
    );

    tpg_pattern #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_pattern (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .restart (reload),
        .wlen_m1 (t_q.wlen_m1),
        .word    (t_q.word),
        .src_bit (word_bit)
    );

    tpg_errins #(.RATE_W(RATE_W), .MAX_DECADE(MAX_DECADE), .SEL_W(SEL_W)) u_errins (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .reload     (reload),
        .single_req (err_single),
        .sel_wr     (sel_wr),
        .sel_in     (sel_in),
        .flip       (flip)
    );

    always_comb begin
        t_d = t_q;
        if (adv) begin
            t_d.tx = (t_q.word_mode ? word_bit : prbs_bit) ^ flip;
        end
        if (cfg_wr) begin
            case (cfg_addr)
                ADDR_W'(CFG_CTRL): t_d.word_mode = cfg_wdata[CTRL_MODE_BIT];
                ADDR_W'(CFG_LEN):  t_d.len_m1    = cfg_wdata[LEN_W-1:0];
                ADDR_W'(CFG_TAPS): t_d.taps      = cfg_wdata;
                ADDR_W'(CFG_WORD): t_d.word      = cfg_wdata;
                ADDR_W'(CFG_WLEN): t_d.wlen_m1   = cfg_wdata[LEN_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.word_mode <= 1'b0;
            t_q.len_m1    <= LEN_W'(DEF_LEN_M1);
            t_q.taps      <= DEF_TAPS;
            t_q.word      <= '0;
            t_q.wlen_m1   <= '0;
            t_q.tx        <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign tx_bit = t_q.tx;

    p_gap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(tx_bit));

    p_reload_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> $stable(tx_bit));

endmodule

// File: tb/tpg_top_tb.sv
`timescale 1ns/1ps
module tpg_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0, rl_i = 1'b0, se_i = 1'b0, wr_i = 1'b0;
    logic [2:0]  addr_i = '0;
    logic [31:0] data_i = '0;
    logic        tx_bit;

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit    finished = 0;

    always #2 clk = ~clk;

    tpg_top u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en(en_i), .reload(rl_i),
        .err_single(se_i), .cfg_wr(wr_i), .cfg_addr(addr_i),
        .cfg_wdata(data_i), .tx_bit(tx_bit)
    );

    function automatic int pw10(input int n);
        int r = 1;
        for (int k = 0; k < n; k++) r = r * 10;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // behavioural reference model
    bit          m_st[32];
    int          m_len, m_pos, m_wlen, m_sel, m_cnt;
    bit          m_mode, m_pend, m_exp;
    logic [31:0] m_taps, m_word;

    always @(posedge clk) begin
        bit adv, selwr, any, fb, pb, rb, hit;
        if (!rst_n) begin
            foreach (m_st[k]) m_st[k] = 0;
            m_st[0] = 1; m_len = 15; m_taps = 32'h6000; m_word = 0; m_wlen = 1;
            m_pos = 0; m_sel = 0; m_cnt = 0; m_mode = 0; m_pend = 0; m_exp = 0;
        end else begin
            adv   = en_i && !rl_i;
            selwr = wr_i && addr_i == 3'd0;
            if (rl_i) begin
                foreach (m_st[k]) m_st[k] = 0;
                m_st[0] = 1; m_pos = 0;
                if (!selwr) m_cnt = pw10(m_sel) - 1;
            end
            if (adv) begin
                pb = m_word[m_pos];
                m_pos = (m_pos >= m_wlen - 1) ? 0 : m_pos + 1;
                any = 0; fb = 0;
                for (int k = 0; k < m_len; k++) begin
                    any = any | m_st[k];
                    fb  = fb ^ (m_st[k] & m_taps[k]);
                end
                if (!any) begin
                    rb = 0; m_st[0] = 1;
                end else begin
                    rb = m_st[m_len-1];
                    for (int k = m_len - 1; k > 0; k--) m_st[k] = m_st[k-1];
                    m_st[0] = fb;
                end
                for (int k = m_len; k < 32; k++) m_st[k] = 0;
                hit   = (m_sel != 0) && !selwr && (m_cnt == 0);
                m_exp = (m_mode ? pb : rb) ^ (m_pend | hit);
            end
            m_pend = (m_pend && !adv) || se_i;
            if (selwr) m_cnt = pw10(int'(data_i[3:1])) - 1;
            else if (adv && m_sel != 0) m_cnt = (m_cnt == 0) ? pw10(m_sel) - 1 : m_cnt - 1;
            if (wr_i) begin
                case (addr_i)
                    3'd0: begin m_mode = data_i[0]; m_sel = int'(data_i[3:1]); end
                    3'd1: m_len  = int'(data_i[4:0]) + 1;
                    3'd2: m_taps = data_i;
                    3'd3: m_word = data_i;
                    3'd4: m_wlen = int'(data_i[4:0]) + 1;
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) check(tx_bit === m_exp, cur_req, int'(tx_bit), int'(m_exp));
    end

    task automatic tick(input bit en, rl, se, w, input logic [2:0] a,
                        input logic [31:0] d, output bit b);
        @(negedge clk);
        en_i = en; rl_i = rl; se_i = se; wr_i = w; addr_i = a; data_i = d;
        @(posedge clk);
        #1 b = tx_bit;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bit b;
        tick(0, 0, 0, 1, a, d, b);
    endtask

    task automatic rld();
        bit b;
        tick(1, 1, 0, 0, 0, 0, b);
    endtask

    task automatic adv1(input bit se, output bit b);
        tick(1, 0, se, 0, 0, 0, b);
    endtask

    bit ref6[126];
    bit got[130];

    initial begin
        bit b;
        int ones, diffs;
        bit okv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 check(tx_bit === 1'b0, "R1", int'(tx_bit), 0);

        cur_req = "R1";
        for (int i = 0; i < 40; i++) adv1(0, b);

        // R2 / R3: length 6, taps at bits 5 and 4
        cur_req = "R3";
        wr(3'd1, 32'd5);
        wr(3'd2, 32'h30);
        rld();
        for (int i = 0; i < 126; i++) begin adv1(0, b); ref6[i] = b; end
        okv = 1; ones = 0;
        for (int i = 0; i < 63; i++) begin
            if (ref6[i] != ref6[i+63]) okv = 0;
            ones += int'(ref6[i]);
        end
        check(okv, "R3 period 63", int'(okv), 1);
        check(ones == 32, "R3 ones", ones, 32);

        // R6: gapped run must give the ungapped stream
        cur_req = "R6";
        rld();
        begin
            int n = 0, c = 0;
            while (n < 63) begin
                bit e = (c % 3) != 2;
                tick(e, 0, 0, 0, 0, 0, b);
                if (e) begin got[n] = b; n++; end
                c++;
            end
        end
        diffs = 0;
        for (int i = 0; i < 63; i++) if (got[i] != ref6[i]) diffs++;
        check(diffs == 0, "R6 gapped stream", diffs, 0);

        // R10: one inversion, later bits unchanged
        cur_req = "R10";
        rld();
        for (int i = 0; i < 126; i++) begin adv1(i == 20, b); got[i] = b; end
        diffs = 0;
        for (int i = 0; i < 126; i++) if (got[i] != ref6[i]) diffs++;
        check(diffs == 1, "R10 single difference", diffs, 1);
        check(got[21] != ref6[21], "R10 flipped position", int'(got[21]), int'(!ref6[21]));

        // R4: no taps, state drains to zero and reseeds
        cur_req = "R4";
        wr(3'd2, 32'h0);
        rld();
        ones = 0; okv = 1;
        for (int i = 0; i < 21; i++) begin
            adv1(0, b); ones += int'(b);
            if (b != ((i % 7) == 5)) okv = 0;
        end
        check(ones == 3, "R4 ones", ones, 3);
        check(okv, "R4 positions", int'(okv), 1);

        // R5: word mode, 5 bits
        cur_req = "R5";
        wr(3'd0, 32'd1);
        wr(3'd3, 32'b10110);
        wr(3'd4, 32'd4);
        rld();
        okv = 1;
        for (int i = 0; i < 15; i++) begin adv1(0, b); if (b != ((32'b10110 >> (i % 5)) & 1)) okv = 0; end
        check(okv, "R5 five-bit word", int'(okv), 1);

        // R7: reload mid-word restarts at bit 0
        cur_req = "R7";
        adv1(0, b); adv1(0, b);
        rld();
        okv = 1;
        for (int i = 0; i < 5; i++) begin adv1(0, b); if (b != ((32'b10110 >> i) & 1)) okv = 0; end
        check(okv, "R7 restart at bit 0", int'(okv), 1);

        // R5: full 32-bit word
        cur_req = "R5";
        wr(3'd3, 32'hC3A5_0F96);
        wr(3'd4, 32'd31);
        rld();
        okv = 1;
        for (int i = 0; i < 64; i++) begin adv1(0, b); if (b != ((32'hC3A5_0F96 >> (i % 32)) & 1)) okv = 0; end
        check(okv, "R5 32-bit word", int'(okv), 1);

        // R8: two strobes before one sent bit give one inversion
        cur_req = "R8";
        wr(3'd3, 32'd0);
        wr(3'd4, 32'd0);
        tick(0, 0, 1, 0, 0, 0, b);
        tick(0, 0, 1, 0, 0, 0, b);
        ones = 0;
        for (int i = 0; i < 10; i++) begin adv1(0, b); ones += int'(b); end
        check(ones == 1, "R8 merged strobes", ones, 1);

        // R9: decade 1 and decade 2
        cur_req = "R9";
        wr(3'd0, 32'd1 | (32'd1 << 1));
        ones = 0; okv = 1;
        for (int i = 0; i < 100; i++) begin
            adv1(0, b); ones += int'(b);
            if (b != ((i % 10) == 9)) okv = 0;
        end
        check(ones == 10, "R9 decade 1 count", ones, 10);
        check(okv, "R9 decade 1 positions", int'(okv), 1);
        wr(3'd0, 32'd1 | (32'd2 << 1));
        ones = 0;
        for (int i = 0; i < 300; i++) begin adv1(0, b); ones += int'(b); end
        check(ones == 3, "R9 decade 2 count", ones, 3);

        // R11: single error and rate hit on the same bit
        cur_req = "R11";
        wr(3'd0, 32'd1 | (32'd1 << 1));
        ones = 0;
        for (int i = 0; i < 20; i++) begin
            adv1(i == 8, b); ones += int'(b);
            if (i == 9) check(b == 1'b1, "R11 coincident bit", int'(b), 1);
        end
        check(ones == 2, "R11 count", ones, 2);

        for (int i = 0; i < 3; i++) tick(0, 0, 0, 0, 0, 0, b);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #600000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule